// File: doc/BRIEF.md
# Bridge Configuration Register Bank

This block holds the type-1 (bridge) configuration header of a bus-to-bus bridge. Configuration accesses arrive on a simple dword-addressed port with per-byte write enables. Reads return the whole dword one cycle later. The header holds the identity words, the command and status words, the three bus numbers, the secondary latency timer, the I/O, memory and prefetchable base/limit windows with their upper extensions, the secondary status and the bridge control word.

Two side effects are derived from writes. Any write whose enabled bytes land on a register that shapes the forwarding windows raises a one-cycle remap strobe, so that the address decoder downstream reloads its windows. Setting the secondary-bus-reset bit in bridge control from 0 to 1 produces a one-cycle reset pulse for the secondary bus.

A build-time option picks the reset state of the windows. Either every range field is cleared, or every base is loaded with all ones and every limit with zeros, so that no window forwards until software programs it.

Top module: `bridge_cfg_bank`

## Requirements
- R1: After reset the dword at index 6 (primary, secondary, subordinate bus numbers, secondary latency timer) reads 0, the command word (index 1, bits 15:0) reads 0, and the dword at index 15 (interrupt line bits 7:0, bridge control bits 31:16) reads 0.
- R2: With FWD_OFF=0, reset clears all writable range bits of the I/O base/limit (index 7), the memory base/limit (index 8) and the prefetchable base/limit (index 9). It also zeroes the prefetchable base/limit upper dwords (indices 10, 11) and the I/O upper halves (index 12).
- R3: With FWD_OFF=1, reset loads every writable range bit of each base field with 1 and every limit field with 0. Index 7 reads 0x00A001F1, index 8 reads 0x0000FFF0 and index 9 reads 0x0001FFF1.
- R4: A write asserts remap_stb for exactly one cycle, the cycle after the write edge, when its enabled bytes touch any of these: index 1 bytes 0–1 (command), index 7 bytes 0–1 (I/O base/limit), any byte of indices 8 to 12, or index 15 bytes 2–3 (bridge control).
- R5: No strobe follows a write that touches none of those bytes. Examples are the bus numbers, the status bytes, the interrupt line, the secondary status bytes, or a write with all byte enables low.
- R6: sec_rst_pulse is high for one cycle, the cycle after a write edge, only when bridge control bit 6 (dword bit 22 of index 15) goes from 0 to 1. Rewriting it as 1, or clearing it, gives no pulse.
- R7: The primary status (index 1, bits 31:16) and the secondary status (index 7, bits 31:16) always read 0x00A0, which means 66 MHz capable and fast back-to-back capable. Writes do not change them.
- R8: Index 2 bits 31:8 read the bridge class code 0x060400. Index 3 bits 23:16 read 0x01, with bit 23 set to the MULTI_FN parameter.
- R9: A write changes only the bytes whose enable bit is set. cfg_be bit i covers cfg_wdata bits 8i+7:8i.
- R10: Read-only bits ignore write data. With IO_32=1 and PREF_64=1, all-ones writes read back 0x00A00147 at index 1, 0x00A0F1F1 at index 7, 0xFFF0FFF0 at index 8, 0xFFF1FFF1 at index 9 and 0x004F00FF at index 15.
- R11: cfg_rdata shows the addressed dword in the cycle after a cfg_rd edge and holds its value while cfg_rd is low.
- R12: With the 64-bit and 32-bit options set, indices 10, 11 and 12 are fully writable 32-bit registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write request for this cycle |
| cfg_rd | input | 1 | Read request for this cycle |
| cfg_addr | input | ADDR_W | Dword index into the header |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_rd |
| remap_stb | output | 1 | One-cycle pulse after a window-related write |
| sec_rst_pulse | output | 1 | One-cycle secondary bus reset pulse |

## Verification
The bench checks the strobe against byte enables at the edges of each sensitive span. It writes only the status bytes of the command dword, only the interrupt line next to bridge control, and only the secondary status next to the I/O base/limit pair. A decoder that worked on dword granularity would strobe on all three. Bus-reset tests rewrite bit 6 while it is already set, then clear it. A level-sensitive design would pulse again, and one that detected any change would pulse on the clear. All-ones writes and half-masked writes show whether read-only type nibbles and status words are overwritten and whether byte lanes are swapped. A second instance built with forwarding disabled shows whether base and limit reset values are swapped.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;

  localparam int unsigned D_ID     = 0;
  localparam int unsigned D_CMD    = 1;
  localparam int unsigned D_CLASS  = 2;
  localparam int unsigned D_HDR    = 3;
  localparam int unsigned D_BUS    = 6;
  localparam int unsigned D_IOBL   = 7;
  localparam int unsigned D_MEMBL  = 8;
  localparam int unsigned D_PREFBL = 9;
  localparam int unsigned D_PBU    = 10;
  localparam int unsigned D_PLU    = 11;
  localparam int unsigned D_IOU    = 12;
  localparam int unsigned D_BCTL   = 15;

  localparam int unsigned WIN_SLOTS = 6;        // indices 7..12
  localparam logic [31:0] STATUS_CONST = 32'h00A0_0000;
  localparam logic [23:0] CLASS_BRIDGE = 24'h060400;
  localparam int unsigned BUS_RST_BIT  = 22;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] merge_write(input logic [31:0] old_v,
                                              input logic [31:0] wd,
                                              input logic [3:0]  be,
                                              input logic [31:0] wmask);
    logic [31:0] m;
    m = wmask & lane_mask(be);
    return (old_v & ~m) | (wd & m);
  endfunction

  // does a write with these byte enables touch a window-shaping register
  function automatic logic touches_window(input logic [31:0] idx,
                                          input logic [3:0]  be);
    logic hit;
    hit = 1'b0;
    if (idx == D_CMD || idx == D_IOBL) hit = |be[1:0];
    else if (idx >= D_MEMBL && idx <= D_IOU) hit = |be;
    else if (idx == D_BCTL) hit = |be[3:2];
    return hit;
  endfunction

  function automatic logic [31:0] win_wmask(input int unsigned slot,
                                            input logic io32,
                                            input logic pref64);
    case (slot)
      0:       return 32'h0000_F0F0;
      1, 2:    return 32'hFFF0_FFF0;
      3, 4:    return pref64 ? 32'hFFFF_FFFF : 32'h0;
      5:       return io32 ? 32'hFFFF_FFFF : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] win_reset(input int unsigned slot,
                                            input logic fwd_off);
    case (slot)
      0:       return fwd_off ? 32'h0000_00F0 : 32'h0;
      1, 2:    return fwd_off ? 32'h0000_FFF0 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/bridge_cfg_slot.sv
module bridge_cfg_slot #(
  parameter int unsigned INDEX = 0,
  parameter logic [31:0] WMASK = 32'h0,
  parameter logic [31:0] RVAL  = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] idx,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  import bridge_cfg_pkg::*;

  logic sel;
  assign sel = wr && (idx == INDEX);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= RVAL;
    else if (sel) q <= merge_write(q, wdata, be, WMASK);
  end
endmodule

// File: rtl/bridge_cfg_win.sv
module bridge_cfg_win #(
  parameter logic IO_32   = 1'b1,
  parameter logic PREF_64 = 1'b1,
  parameter logic FWD_OFF = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] idx,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [bridge_cfg_pkg::WIN_SLOTS-1:0][31:0] win_q
);
  import bridge_cfg_pkg::*;

  for (genvar s = 0; s < WIN_SLOTS; s++) begin : g_slot
    bridge_cfg_slot #(
      .INDEX(D_IOBL + s),
      .WMASK(win_wmask(s, IO_32, PREF_64)),
      .RVAL (win_reset(s, FWD_OFF))
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx), .be(be),
      .wdata(wdata), .q(win_q[s])
    );
  end
endmodule

// File: rtl/bridge_cfg_ctl.sv
module bridge_cfg_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] idx,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] cmd_q,
  output logic [31:0] bus_q,
  output logic [31:0] bctl_q,
  output logic        bus_rst_bit,
  output logic        rst_rise,
  output logic        sec_rst_pulse
);
  import bridge_cfg_pkg::*;

  localparam logic [31:0] CMD_WMASK  = 32'h0000_0147;
  localparam logic [31:0] BUS_WMASK  = 32'hFFFF_FFFF;
  localparam logic [31:0] BCTL_WMASK = 32'h004F_00FF;

  bridge_cfg_slot #(.INDEX(D_CMD), .WMASK(CMD_WMASK), .RVAL(32'h0)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx), .be(be),
    .wdata(wdata), .q(cmd_q));

  bridge_cfg_slot #(.INDEX(D_BUS), .WMASK(BUS_WMASK), .RVAL(32'h0)) u_bus (
    .clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx), .be(be),
    .wdata(wdata), .q(bus_q));

  bridge_cfg_slot #(.INDEX(D_BCTL), .WMASK(BCTL_WMASK), .RVAL(32'h0)) u_bctl (
    .clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx), .be(be),
    .wdata(wdata), .q(bctl_q));

  logic [31:0] bctl_next;
  assign bus_rst_bit = bctl_q[BUS_RST_BIT];
  assign bctl_next   = merge_write(bctl_q, wdata, be, BCTL_WMASK);
  assign rst_rise    = wr && (idx == D_BCTL) && !bus_rst_bit
                       && bctl_next[BUS_RST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) sec_rst_pulse <= 1'b0;
    else        sec_rst_pulse <= rst_rise;
  end
endmodule

// File: rtl/bridge_cfg_bank.sv
module bridge_cfg_bank #(
  parameter int unsigned ADDR_W    = 6,
  parameter logic [15:0] VENDOR_ID = 16'hABCD,
  parameter logic [15:0] DEVICE_ID = 16'h0042,
  parameter logic [7:0]  REV_ID    = 8'h00,
  parameter logic        MULTI_FN  = 1'b0,
  parameter logic        IO_32     = 1'b1,
  parameter logic        PREF_64   = 1'b1,
  parameter logic        FWD_OFF   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              remap_stb,
  output logic              sec_rst_pulse
);
  import bridge_cfg_pkg::*;

  localparam logic [3:0]  IO_TYPE   = {3'b000, IO_32};
  localparam logic [3:0]  PREF_TYPE = {3'b000, PREF_64};
  localparam logic [31:0] IOBL_RO   = STATUS_CONST | {20'h0, IO_TYPE, 4'h0, IO_TYPE};
  localparam logic [31:0] PREF_RO   = {12'h0, PREF_TYPE, 12'h0, PREF_TYPE};
  localparam logic [31:0] HDR_RO    = {8'h00, MULTI_FN, 7'h01, 16'h0000};

  logic [31:0] idx;
  assign idx = 32'(cfg_addr);

  // named internal events, observed by the bound checker
  logic win_hit;
  logic bus_rst_bit;
  logic rst_rise;
  assign win_hit = cfg_wr && touches_window(idx, cfg_be);

  logic [WIN_SLOTS-1:0][31:0] win_q;
  logic [31:0] cmd_q, bus_q, bctl_q;

  bridge_cfg_win #(.IO_32(IO_32), .PREF_64(PREF_64), .FWD_OFF(FWD_OFF)) u_win (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(idx), .be(cfg_be),
    .wdata(cfg_wdata), .win_q(win_q));

  bridge_cfg_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(idx), .be(cfg_be),
    .wdata(cfg_wdata), .cmd_q(cmd_q), .bus_q(bus_q), .bctl_q(bctl_q),
    .bus_rst_bit(bus_rst_bit), .rst_rise(rst_rise),
    .sec_rst_pulse(sec_rst_pulse));

  logic [31:0] rd_mux;
  always_comb begin
    case (idx)
      D_ID:     rd_mux = {DEVICE_ID, VENDOR_ID};
      D_CMD:    rd_mux = cmd_q | STATUS_CONST;
      D_CLASS:  rd_mux = {CLASS_BRIDGE, REV_ID};
      D_HDR:    rd_mux = HDR_RO;
      D_BUS:    rd_mux = bus_q;
      D_IOBL:   rd_mux = win_q[0] | IOBL_RO;
      D_MEMBL:  rd_mux = win_q[1];
      D_PREFBL: rd_mux = win_q[2] | PREF_RO;
      D_PBU:    rd_mux = win_q[3];
      D_PLU:    rd_mux = win_q[4];
      D_IOU:    rd_mux = win_q[5];
      D_BCTL:   rd_mux = bctl_q;
      default:  rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata <= 32'h0;
      remap_stb <= 1'b0;
    end else begin
      remap_stb <= win_hit;
      if (cfg_rd) cfg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/bridge_cfg_chk.sv
module bridge_cfg_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_rdata,
  input logic              remap_stb,
  input logic              sec_rst_pulse,
  input logic              bus_rst_bit
);
  a_r4_mem_window_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == ADDR_W'(8) && cfg_be != 4'h0) |=> remap_stb);

  a_r5_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> !remap_stb);

  a_r5_busnum_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == ADDR_W'(6)) |=> !remap_stb);

  a_r6_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sec_rst_pulse |-> (bus_rst_bit && !$past(bus_rst_bit)));

  a_r6_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> !sec_rst_pulse);

  a_r7_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == ADDR_W'(1)) |=> cfg_rdata[31:16] == 16'h00A0);

  a_r8_class_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == ADDR_W'(2)) |=> cfg_rdata[31:8] == 24'h060400);

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata));
endmodule

bind bridge_cfg_bank bridge_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
  .remap_stb(remap_stb), .sec_rst_pulse(sec_rst_pulse),
  .bus_rst_bit(bus_rst_bit));

// File: tb/tb_bridge_cfg_bank.sv
module tb_bridge_cfg_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rdata, rdata_nf;
  logic remap, pulse, remap_nf, pulse_nf;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bridge_cfg_bank dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata), .remap_stb(remap), .sec_rst_pulse(pulse));

  bridge_cfg_bank #(.FWD_OFF(1'b1), .MULTI_FN(1'b1)) dut_nf (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_nf), .remap_stb(remap_nf), .sec_rst_pulse(pulse_nf));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [5:0] idx, output logic [31:0] a, output logic [31:0] b);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = idx;
    @(negedge clk);
    cfg_rd = 1'b0;
    a = rdata; b = rdata_nf;
  endtask

  // write, then check strobe and pulse in the following cycle and their fall after
  task automatic wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d,
                    input logic exp_remap, input logic exp_pulse, input string tag);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
    chk({tag, " remap"}, {31'h0, remap}, {31'h0, exp_remap});
    chk({tag, " pulse"}, {31'h0, pulse}, {31'h0, exp_pulse});
    @(negedge clk);
    chk({tag, " remap one cycle"}, {31'h0, remap}, 32'h0);
    chk({tag, " pulse one cycle"}, {31'h0, pulse}, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] a, b;
    rd(6'd6, a, b);  chk("R1 bus numbers", a, 32'h0);
    rd(6'd15, a, b); chk("R1 bridge control", a, 32'h0);
    rd(6'd1, a, b);  chk("R1 R7 command/status", a, 32'h00A0_0000);
    rd(6'd7, a, b);  chk("R2 io base/limit", a, 32'h00A0_0101);
                     chk("R3 io base/limit fwd off", b, 32'h00A0_01F1);
    rd(6'd8, a, b);  chk("R2 mem base/limit", a, 32'h0);
                     chk("R3 mem base/limit fwd off", b, 32'h0000_FFF0);
    rd(6'd9, a, b);  chk("R2 pref base/limit", a, 32'h0001_0001);
                     chk("R3 pref base/limit fwd off", b, 32'h0001_FFF1);
    for (int i = 10; i <= 12; i++) begin
      rd(6'(i), a, b);
      chk("R2 upper registers", a, 32'h0);
      chk("R3 upper registers fwd off", b, 32'h0);
    end
  endtask

  task automatic t_ident;
    logic [31:0] a, b;
    rd(6'd2, a, b); chk("R8 class code", a, 32'h0604_0000);
    rd(6'd3, a, b); chk("R8 header type", a, 32'h0001_0000);
                    chk("R8 header type multifunction", b, 32'h0081_0000);
  endtask

  task automatic t_bytes;
    logic [31:0] a, b;
    wr(6'd6, 4'b0101, 32'h4433_2211, 1'b0, 1'b0, "R5 bus numbers");
    rd(6'd6, a, b); chk("R9 even lanes", a, 32'h0033_0011);
    wr(6'd6, 4'b1010, 32'hDDCC_BBAA, 1'b0, 1'b0, "R5 bus numbers");
    rd(6'd6, a, b); chk("R9 odd lanes", a, 32'hDD33_BB11);
    rd(6'd6, a, b);
    @(negedge clk); @(negedge clk);
    chk("R11 rdata holds while idle", rdata, 32'hDD33_BB11);
  endtask

  task automatic t_readonly;
    logic [31:0] a, b;
    wr(6'd1, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R4 command");
    rd(6'd1, a, b); chk("R10 R7 command ones", a, 32'h00A0_0147);
    wr(6'd7, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R4 io base/limit");
    rd(6'd7, a, b); chk("R10 R7 io base/limit ones", a, 32'h00A0_F1F1);
    wr(6'd8, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R4 mem base/limit");
    rd(6'd8, a, b); chk("R10 mem base/limit ones", a, 32'hFFF0_FFF0);
    wr(6'd9, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R4 pref base/limit");
    rd(6'd9, a, b); chk("R10 pref base/limit ones", a, 32'hFFF1_FFF1);
  endtask

  task automatic t_upper;
    logic [31:0] a, b;
    wr(6'd10, 4'hF, 32'h1234_5678, 1'b1, 1'b0, "R4 pref base upper");
    wr(6'd11, 4'hF, 32'h9ABC_DEF0, 1'b1, 1'b0, "R4 pref limit upper");
    wr(6'd12, 4'hF, 32'h0F0F_F0F0, 1'b1, 1'b0, "R4 io upper");
    rd(6'd10, a, b); chk("R12 pref base upper", a, 32'h1234_5678);
    rd(6'd11, a, b); chk("R12 pref limit upper", a, 32'h9ABC_DEF0);
    rd(6'd12, a, b); chk("R12 io upper", a, 32'h0F0F_F0F0);
  endtask

  task automatic t_remap_edges;
    logic [31:0] a, b;
    wr(6'd1, 4'b1100, 32'hFFFF_0000, 1'b0, 1'b0, "R5 status bytes only");
    rd(6'd1, a, b); chk("R7 status after write", a, 32'h00A0_0147);
    wr(6'd7, 4'b1100, 32'hFFFF_0000, 1'b0, 1'b0, "R5 secondary status only");
    rd(6'd7, a, b); chk("R7 secondary status after write", a, 32'h00A0_F1F1);
    wr(6'd15, 4'b0001, 32'h0000_005A, 1'b0, 1'b0, "R5 interrupt line only");
    wr(6'd8, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, "R5 no byte enables");
    rd(6'd8, a, b); chk("R9 no byte enables keeps value", a, 32'hFFF0_FFF0);
    wr(6'd3, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5 header dword");
    wr(6'd15, 4'b0100, 32'h0000_0000, 1'b1, 1'b0, "R4 bridge control");
  endtask

  task automatic t_busrst;
    logic [31:0] a, b;
    wr(6'd15, 4'b0100, 32'h0040_0000, 1'b1, 1'b1, "R6 rise");
    wr(6'd15, 4'b0100, 32'h0040_0000, 1'b1, 1'b0, "R6 held high");
    wr(6'd15, 4'b0100, 32'h0000_0000, 1'b1, 1'b0, "R6 clear");
    wr(6'd15, 4'b1100, 32'hFFFF_FFFF, 1'b1, 1'b1, "R6 rise again");
    rd(6'd15, a, b); chk("R10 bridge control ones", a, 32'h004F_005A);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 remap after reset", {31'h0, remap}, 32'h0);
    chk("R6 pulse after reset", {31'h0, pulse}, 32'h0);
    t_reset();
    t_ident();
    t_bytes();
    t_readonly();
    t_upper();
    t_remap_edges();
    t_busrst();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end
endmodule